// File: doc/BRIEF.md
# Byte-Wide Accumulator Arithmetic and Logic Unit

This block is the purely combinational execution stage of an 8-bit accumulator-style processor. The caller picks one of thirteen operations with a 4-bit code and supplies two operands and the incoming carry. `reg_i` is the accumulator, index register or read-modify-write operand. `mem_i` is the second operand. Within the same cycle the block returns the result byte and a result write enable. It also returns the next values of the negative (N), zero (Z), carry (C) and overflow (V) flags, each with its own update enable.

Binary operations combine `reg_i` with `mem_i`. The single-operand operations act on `reg_i` only. These are increment, decrement and the one-bit shifts and rotates. The caller routes the memory byte into `reg_i` when such an operation targets memory. The status register stays outside the block. The caller writes a flag from the flag output only while that flag's enable is high.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op_i` are 0 AND, 1 OR, 2 XOR, 3 add, 4 subtract, 5 compare, 6 bit test, 7 increment, 8 decrement, 9 shift left, 10 shift right, 11 rotate left, 12 rotate right. Codes 13 to 15 give a result of 0, a low write enable, and all flag enables low.
- R2: AND, OR and XOR combine `reg_i` with `mem_i` bitwise and raise the write enable. They enable only N and Z.
- R3: Add returns the low 8 bits of reg + mem + carry. C is the ninth sum bit. V is set when the signed sum lies outside -128..127. All four flags are enabled.
- R4: Subtract returns reg - mem - (1 - carry). C is set when no borrow occurred. V is set when the signed difference lies outside -128..127. All four flags are enabled.
- R5: Compare presents reg - mem on `result_o` with the write enable low. C is set when reg >= mem, unsigned. N, Z and C are enabled and V is not.
- R6: Bit test takes N from `mem_i` bit 7, V from `mem_i` bit 6, and Z from (reg AND mem) being zero. It enables N, Z and V and keeps the write enable low.
- R7: Increment and decrement add or subtract one modulo 256, write the result, and enable only N and Z.
- R8: Shift left moves bit 7 into C and fills bit 0 with 0. Shift right moves bit 0 into C, fills bit 7 with 0 and gives N = 0. Both write the result and enable N, Z and C.
- R9: Rotate left shifts in the incoming carry at bit 0 and moves bit 7 into C. Rotate right shifts the carry in at bit 7 and moves bit 0 into C. Both write the result and enable N, Z and C.
- R10: Apart from the bit test, N equals result bit 7. Z is set exactly when the result is zero. Every flag output whose enable is low reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (see R1) |
| reg_i | input | 8 | Register / single operand |
| mem_i | input | 8 | Second operand |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 8 | Result byte (difference for compare, AND for bit test) |
| write_o | output | 1 | Result should be written back |
| n_o | output | 1 | Next negative flag |
| z_o | output | 1 | Next zero flag |
| c_o | output | 1 | Next carry flag |
| v_o | output | 1 | Next overflow flag |
| n_we_o | output | 1 | N update enable |
| z_we_o | output | 1 | Z update enable |
| c_we_o | output | 1 | C update enable |
| v_we_o | output | 1 | V update enable |

## Verification
The single-operand operations and the reserved codes are swept over all 256 values of `reg_i` with both carry values, which covers every wrap and every carry-in case of the rotates. The binary operations are swept over all `reg_i` values crossed with `mem_i` in steps of five, with both carries. This set separates carry-in from borrow handling and signed from unsigned overflow. Named corner vectors hit the sign boundaries 0x7F/0x80, equal and zero operands, and the bit-test masks. Those vectors separate a correct V from a plain carry and a copied operand bit from a computed one.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0,
    OP_OR  = 4'd1,
    OP_XOR = 4'd2,
    OP_ADD = 4'd3,
    OP_SUB = 4'd4,
    OP_CMP = 4'd5,
    OP_BIT = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8,
    OP_SHL = 4'd9,
    OP_SHR = 4'd10,
    OP_ROL = 4'd11,
    OP_ROR = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/alu8_logic_unit.sv
module alu8_logic_unit
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o
);
  always_comb begin
    case (op_i)
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      default: res_o = a_i & b_i;  // AND and bit test
    endcase
  end
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o,
  output logic             v_o
);
  localparam int unsigned SW = WIDTH + 1;

  logic [WIDTH-1:0] addend;
  logic             cin_eff;
  logic [SW-1:0]    sum;

  always_comb begin
    addend  = b_i;
    cin_eff = cin_i;
    case (op_i)
      OP_SUB: addend = ~b_i;
      OP_CMP: begin
        addend  = ~b_i;
        cin_eff = 1'b1;
      end
      OP_INC: begin
        addend  = WIDTH'(1);
        cin_eff = 1'b0;
      end
      OP_DEC: begin
        addend  = '1;
        cin_eff = 1'b0;
      end
      default: ;
    endcase
  end

  assign sum   = {1'b0, a_i} + {1'b0, addend} + SW'(cin_eff);
  assign res_o = sum[WIDTH-1:0];
  assign c_o   = sum[WIDTH];
  // overflow: like-signed inputs, result sign flipped
  assign v_o   = (a_i[WIDTH-1] == addend[WIDTH-1]) && (sum[WIDTH-1] != a_i[WIDTH-1]);
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o
);
  always_comb begin
    res_o = a_i;
    c_o   = cin_i;
    case (op_i)
      OP_SHL: begin
        res_o = {a_i[WIDTH-2:0], 1'b0};
        c_o   = a_i[WIDTH-1];
      end
      OP_SHR: begin
        res_o = {1'b0, a_i[WIDTH-1:1]};
        c_o   = a_i[0];
      end
      OP_ROL: begin
        res_o = {a_i[WIDTH-2:0], cin_i};
        c_o   = a_i[WIDTH-1];
      end
      OP_ROR: begin
        res_o = {cin_i, a_i[WIDTH-1:1]};
        c_o   = a_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  alu_op_e          op_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic [1:0]       b_top_i,  // operand bits msb, msb-1
  input  logic             c_i,
  input  logic             v_i,
  output logic             write_o,
  output flags_t           en_o,
  output flags_t           flag_o
);
  flags_t raw;

  always_comb begin
    write_o = 1'b1;
    en_o    = '0;
    case (op_i)
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC: en_o = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
      OP_ADD, OP_SUB:                         en_o = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b1};
      OP_SHL, OP_SHR, OP_ROL, OP_ROR:         en_o = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
      OP_CMP: begin
        en_o    = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
        write_o = 1'b0;
      end
      OP_BIT: begin
        en_o    = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b1};
        write_o = 1'b0;
      end
      default: write_o = 1'b0;
    endcase
  end

  always_comb begin
    raw.n = (op_i == OP_BIT) ? b_top_i[1] : res_i[WIDTH-1];
    raw.z = (res_i == '0);
    raw.c = c_i;
    raw.v = (op_i == OP_BIT) ? b_top_i[0] : v_i;
  end

  assign flag_o = raw & en_o;
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] reg_i,
  input  logic [WIDTH-1:0] mem_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             write_o,
  output logic             n_o,
  output logic             z_o,
  output logic             c_o,
  output logic             v_o,
  output logic             n_we_o,
  output logic             z_we_o,
  output logic             c_we_o,
  output logic             v_we_o
);
  alu_op_e          op;
  logic [WIDTH-1:0] logic_res, add_res, shf_res;
  logic             add_c, add_v, shf_c;
  logic             sel_c;
  flags_t           en, flg;

  assign op = alu_op_e'(op_i);

  alu8_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op_i(op), .a_i(reg_i), .b_i(mem_i), .res_o(logic_res)
  );

  alu8_adder #(.WIDTH(WIDTH)) u_adder (
    .op_i(op), .a_i(reg_i), .b_i(mem_i), .cin_i(carry_i),
    .res_o(add_res), .c_o(add_c), .v_o(add_v)
  );

  alu8_shifter #(.WIDTH(WIDTH)) u_shift (
    .op_i(op), .a_i(reg_i), .cin_i(carry_i), .res_o(shf_res), .c_o(shf_c)
  );

  always_comb begin
    result_o = '0;
    sel_c    = add_c;
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_BIT:          result_o = logic_res;
      OP_ADD, OP_SUB, OP_CMP, OP_INC, OP_DEC: result_o = add_res;
      OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
        result_o = shf_res;
        sel_c    = shf_c;
      end
      default: ;
    endcase
  end

  alu8_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .op_i(op), .res_i(result_o), .b_top_i(mem_i[WIDTH-1 -: 2]),
    .c_i(sel_c), .v_i(add_v), .write_o(write_o), .en_o(en), .flag_o(flg)
  );

  assign n_o    = flg.n;
  assign z_o    = flg.z;
  assign c_o    = flg.c;
  assign v_o    = flg.v;
  assign n_we_o = en.n;
  assign z_we_o = en.z;
  assign c_we_o = en.c;
  assign v_we_o = en.v;
endmodule

// File: rtl/alu8_core_checker.sv
module alu8_core_checker #(
  parameter int unsigned WIDTH = 8
) (
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] reg_i,
  input logic [WIDTH-1:0] mem_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             write_o,
  input logic             n_o,
  input logic             z_o,
  input logic             c_o,
  input logic             v_o,
  input logic             n_we_o,
  input logic             z_we_o,
  input logic             c_we_o,
  input logic             v_we_o
);
  always_comb begin
    if (z_we_o)
      assert_z_tracks_result_R10: assert (z_o == (result_o == '0));
    if (n_we_o && op_i != 4'd6)
      assert_n_tracks_msb_R10: assert (n_o == result_o[WIDTH-1]);
    if (!c_we_o)
      assert_c_gated_R10: assert (!c_o);
    if (op_i == 4'd5)
      assert_cmp_unsigned_R5: assert (!write_o && !v_we_o && c_o == (reg_i >= mem_i));
    if (op_i == 4'd6)
      assert_bit_copy_R6: assert (!write_o && n_o == mem_i[WIDTH-1] && v_o == mem_i[WIDTH-2]);
    if (op_i == 4'd7 || op_i == 4'd8)
      assert_incdec_keep_cv_R7: assert (write_o && !c_we_o && !v_we_o);
    if (op_i == 4'd10)
      assert_shr_n_clear_R8: assert (c_we_o && !n_o && c_o == reg_i[0]);
    if (op_i == 4'd11)
      assert_rol_carry_in_R9: assert (result_o[0] == carry_i && c_o == reg_i[WIDTH-1]);
    if (op_i > 4'd12)
      assert_reserved_idle_R1: assert (!write_o && !n_we_o && !z_we_o && !c_we_o && !v_we_o);
  end
endmodule

bind alu8_core alu8_core_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_core_test.sv
module alu8_core_test;
  logic       clk = 1'b0;
  logic [3:0] op_i = '0;
  logic [7:0] reg_i = '0, mem_i = '0;
  logic       carry_i = 1'b0;
  logic [7:0] result_o;
  logic       write_o, n_o, z_o, c_o, v_o, n_we_o, z_we_o, c_we_o, v_we_o;
  int         errors = 0, checks = 0, cycles = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  alu8_core uut (
    .op_i, .reg_i, .mem_i, .carry_i, .result_o, .write_o,
    .n_o, .z_o, .c_o, .v_o, .n_we_o, .z_we_o, .c_we_o, .v_we_o
  );

  function automatic string req_of(int op);
    case (op)
      0, 1, 2: return "R2";
      3:       return "R3";
      4:       return "R4";
      5:       return "R5";
      6:       return "R6";
      7, 8:    return "R7";
      9, 10:   return "R8";
      11, 12:  return "R9";
      default: return "R1";
    endcase
  endfunction

  function automatic int sx(int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // {write, result[7:0], n, z, c, v, n_we, z_we, c_we, v_we}
  function automatic logic [16:0] model(int op, int r, int m, int c);
    int t = 0, s = 0, res = 0;
    bit we = 1'b1, n = 1'b0, z = 1'b0, cf = 1'b0, vf = 1'b0;
    logic [3:0] en = 4'b1100;
    case (op)
      0: res = r & m;
      1: res = r | m;
      2: res = r ^ m;
      3: begin
        t = r + m + c; res = t & 255; cf = (t > 255);
        s = sx(r) + sx(m) + c; vf = (s > 127 || s < -128); en = 4'b1111;
      end
      4: begin
        t = r - m - (1 - c); res = t & 255; cf = (t >= 0);
        s = sx(r) - sx(m) - (1 - c); vf = (s > 127 || s < -128); en = 4'b1111;
      end
      5: begin res = (r - m) & 255; cf = (r >= m); en = 4'b1110; we = 1'b0; end
      6: begin res = r & m; vf = m[6]; en = 4'b1101; we = 1'b0; end
      7: res = (r + 1) & 255;
      8: res = (r + 255) & 255;
      9:  begin res = (r * 2) & 255;       cf = (r >= 128); en = 4'b1110; end
      10: begin res = r / 2;               cf = r[0];       en = 4'b1110; end
      11: begin res = (r * 2 + c) & 255;   cf = (r >= 128); en = 4'b1110; end
      12: begin res = r / 2 + c * 128;     cf = r[0];       en = 4'b1110; end
      default: begin res = 0; we = 1'b0; en = 4'b0000; end
    endcase
    n = (op == 6) ? m[7] : res[7];
    z = (res == 0);
    return {we, 8'(res), n & en[3], z & en[2], cf & en[1], vf & en[0], en};
  endfunction

  task automatic apply(int op, int r, int m, int c, string tag);
    logic [16:0] exp_v, got;
    op_i = 4'(op); reg_i = 8'(r); mem_i = 8'(m); carry_i = c[0];
    #1;
    exp_v = model(op, r, m, c);
    got   = {write_o, result_o, n_o, z_o, c_o, v_o, n_we_o, z_we_o, c_we_o, v_we_o};
    checks++;
    if (got !== exp_v) begin
      errors++;
      $display("FAIL %s op=%0d reg=%02h mem=%02h c=%0d got=%05h exp=%05h",
               tag, op, r, m, c, got, exp_v);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // idle state with all-zero inputs: AND of zeros, Z set (R2, R10)
    apply(0, 0, 0, 0, "R2");
    // signed/unsigned boundaries (R3, R4, R10)
    apply(3, 8'h7F, 8'h01, 0, "R3");  // V set, N set
    apply(3, 8'h80, 8'h80, 0, "R3");  // C, V, Z
    apply(3, 8'hFF, 8'h00, 1, "R10");
    apply(4, 8'h80, 8'h01, 1, "R4");  // V set
    apply(4, 8'h00, 8'h00, 0, "R4");  // borrow -> FF, C clear
    apply(4, 8'h50, 8'h50, 1, "R10");
    apply(5, 8'h40, 8'h40, 0, "R5");
    apply(5, 8'h7F, 8'h80, 1, "R5");
    apply(6, 8'h0F, 8'hC0, 0, "R6");
    apply(6, 8'hFF, 8'h41, 0, "R6");
    apply(7, 8'hFF, 0, 1, "R7");
    apply(8, 8'h00, 0, 1, "R7");
    apply(10, 8'h01, 0, 0, "R8");
    apply(12, 8'h00, 0, 1, "R9");
    apply(13, 8'hAA, 8'h55, 1, "R1");
    // single-operand ops and reserved codes: exhaustive over reg and carry
    for (int op = 7; op < 16; op++)
      for (int r = 0; r < 256; r++)
        for (int c = 0; c < 2; c++)
          apply(op, r, (r * 7) & 255, c, req_of(op));
    // binary ops: all reg, mem stepped by 5
    for (int op = 0; op < 7; op++)
      for (int r = 0; r < 256; r++)
        for (int m = 0; m < 256; m += 5)
          for (int c = 0; c < 2; c++)
            apply(op, r, m, c, req_of(op));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule